// File: doc/BRIEF.md
# ADC Serial Readout Controller

This block is the host side of a three-wire link to a 12-bit serial sampling converter. It drives an active-low chip select and a shift clock, and rebuilds each 12-bit conversion result from the serial data line. A conversion begins when chip select falls. The converter then sends two leading zeros, twelve data bits with the most significant bit first, and two trailing zeros. The converter changes its data line on each falling shift-clock edge. The controller samples that line on rising edges.

The shift clock rests high. Each half period lasts `div_i + 1` system clock cycles, and the divider value is latched when a frame starts. A normal conversion frame runs 16 shift clocks, or 14 shift clocks when the trailing zeros are not needed. The converter's power state is controlled only by where chip select is released. A sleep frame releases it early, after a few clocks. A wake frame is a full 16-clock dummy conversion whose data is thrown away. Each result arrives with a one-cycle valid strobe. An error strobe reports any zero position that was read back as a one.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is high and after it is released, `cs_n_o` is 1, `sck_o` is 1, and `busy_o`, `valid_o` and `err_o` are 0.
- R2: The shift clock rests high. The first falling shift-clock edge comes `div_i+1` system cycles after chip select falls. Each low and each high half period lasts `div_i+1` cycles.
- R3: A conversion frame has 16 falling shift-clock edges when `long_frame_i` is 1 and 14 when it is 0. Chip select rises only after the last rising edge of the frame.
- R4: The rising edge numbered 1 is taken as the second leading zero. Rising edges 2 to 13 capture result bits 11 down to 0, so `result_o[11]` is the first bit captured.
- R5: At the end of a conversion frame, `valid_o` pulses high for exactly one cycle and `result_o` holds the new result.
- R6: When `sleep_i` is accepted, the frame has exactly SLEEP_CLKS falling edges (default 4, and always more than 2 and fewer than 10). Chip select is then released and no valid strobe is produced.
- R7: When `wake_i` is accepted, the frame is a 16-clock dummy frame with no valid strobe.
- R8: At the end of any frame that is not a sleep frame, `err_o` pulses for one cycle if the bit sampled on rising edge 1, 14 or 15 was 1 (only edges that exist in the frame are counted). A 1 on any position after the last rising edge is not counted.
- R9: Between two frames, chip select stays high for at least `2*(div_i+1)` system cycles.
- R10: Requests are accepted only when the block is idle. If several arrive together, wake wins over sleep, and sleep wins over start. A request made while a frame is running has no effect.
- R11: `busy_o` is high from the cycle in which chip select falls until the gap after the frame has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a conversion frame |
| sleep_i | input | 1 | Request a sleep frame |
| wake_i | input | 1 | Request a wake (dummy) frame |
| long_frame_i | input | 1 | 1: 16-clock conversion frame, 0: 14-clock frame |
| div_i | input | DIV_W | Shift-clock half period minus one, in system cycles |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Shift clock, rests high |
| result_o | output | 12 | Most recent conversion result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| err_o | output | 1 | One-cycle strobe when a zero position read as 1 |
| busy_o | output | 1 | A frame or the gap after it is in progress |

## Verification
Conversion frames are run with both frame lengths and several divider values. The data words include alternating bits, all ones, all zeros and patterns set only at the ends of the word. These show whether bits are shifted in the wrong direction, whether the capture window is off by one edge, and whether the timing counts off the latched divider. Sleep and wake frames are separated from conversions by their falling-edge count and by the missing valid strobe. Sending requests at the same time, and in the middle of a frame, tests the priority rule and the idle-only rule. Bench models that put a 1 on a leading zero, on a trailing zero, or just past the last edge show whether the error check covers exactly the positions that were sampled.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    localparam int DATA_W      = 12;
    localparam int LEAD_Z      = 2;
    localparam int FRAME_LONG  = 16;
    localparam int FRAME_SHORT = 14;
    localparam int CLK_CNT_W   = $clog2(FRAME_LONG + 1);

    // rising-edge numbers (1-based) bounding the data window
    localparam logic [CLK_CNT_W-1:0] FIRST_DATA_RISE = CLK_CNT_W'(LEAD_Z);
    localparam logic [CLK_CNT_W-1:0] LAST_DATA_RISE  = CLK_CNT_W'(LEAD_Z + DATA_W - 1);
    localparam logic [CLK_CNT_W-1:0] LAST_ZERO_RISE  = CLK_CNT_W'(FRAME_LONG - 1);

    typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_GAP} seq_st_e;
    typedef enum logic [1:0] {FK_CONV, FK_SLEEP, FK_WAKE} frame_kind_e;

    typedef struct packed {
        frame_kind_e            kind;
        logic [CLK_CNT_W-1:0]   nclk;
    } frame_cfg_t;

    function automatic frame_cfg_t pick_frame(input logic wake, input logic sleep,
                                              input logic long_f, input int sleep_clks);
        frame_cfg_t c;
        if (wake) begin
            c.kind = FK_WAKE;
            c.nclk = CLK_CNT_W'(FRAME_LONG);
        end else if (sleep) begin
            c.kind = FK_SLEEP;
            c.nclk = CLK_CNT_W'(sleep_clks);
        end else begin
            c.kind = FK_CONV;
            c.nclk = long_f ? CLK_CNT_W'(FRAME_LONG) : CLK_CNT_W'(FRAME_SHORT);
        end
        return c;
    endfunction
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int DIV_W      = 4,
    parameter int SLEEP_CLKS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  sleep_req,
    input  logic                  wake_req,
    input  logic                  long_frame,
    input  logic [DIV_W-1:0]      div,
    input  logic                  tmr_done,
    output logic                  tmr_load,
    output logic [DIV_W:0]        tmr_val,
    output logic                  cs_n,
    output logic                  sck,
    output logic                  busy,
    output logic                  rise_stb,
    output logic [CLK_CNT_W-1:0]  rise_idx,
    output logic                  frame_end,
    output frame_kind_e           kind
);
    seq_st_e              state;
    frame_cfg_t           cfg;
    logic [DIV_W-1:0]     div_q;
    logic [CLK_CNT_W-1:0] rcnt;
    logic                 req;
    logic                 last_rise;

    assign req       = start | sleep_req | wake_req;
    assign last_rise = (rcnt == cfg.nclk);
    assign rise_stb  = (state == ST_LOW) && tmr_done;
    assign rise_idx  = rcnt + 1'b1;
    assign frame_end = (state == ST_HIGH) && tmr_done && last_rise;
    assign busy      = (state != ST_IDLE);
    assign kind      = cfg.kind;

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = {1'b0, div_q};
        unique case (state)
            ST_IDLE: begin
                tmr_load = req;
                tmr_val  = {1'b0, div};
            end
            ST_SETUP, ST_LOW: tmr_load = tmr_done;
            ST_HIGH: begin
                tmr_load = tmr_done;
                if (last_rise) tmr_val = {div_q, 1'b1};
            end
            default: tmr_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg   <= '{kind: FK_CONV, nclk: '0};
            div_q <= '0;
            rcnt  <= '0;
            cs_n  <= 1'b1;
            sck   <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: if (req) begin
                    cfg   <= pick_frame(wake_req, sleep_req, long_frame, SLEEP_CLKS);
                    div_q <= div;
                    rcnt  <= '0;
                    cs_n  <= 1'b0;
                    state <= ST_SETUP;
                end
                ST_SETUP: if (tmr_done) begin
                    sck   <= 1'b0;
                    state <= ST_LOW;
                end
                ST_LOW: if (tmr_done) begin
                    sck   <= 1'b1;
                    rcnt  <= rcnt + 1'b1;
                    state <= ST_HIGH;
                end
                ST_HIGH: if (tmr_done) begin
                    if (last_rise) begin
                        cs_n  <= 1'b1;
                        state <= ST_GAP;
                    end else begin
                        sck   <= 1'b0;
                        state <= ST_LOW;
                    end
                end
                ST_GAP: if (tmr_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_sck_rests_high_R2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sck);
    assert_release_after_last_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> ($past(rcnt) == $past(cfg.nclk)) && $past(sck));
    assert_rise_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH) |-> (rcnt != '0) && (rcnt <= cfg.nclk));
    assert_sleep_length_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_n) && cfg.kind == FK_SLEEP) |-> (rcnt == CLK_CNT_W'(SLEEP_CLKS)));
    assert_gap_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> cs_n && sck);
    assert_busy_covers_cs_R11: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
    import adc_rd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rise_stb,
    input  logic [CLK_CNT_W-1:0] rise_idx,
    input  logic                 sdo,
    input  logic                 frame_end,
    input  frame_kind_e          kind,
    output logic [DATA_W-1:0]    result,
    output logic                 valid,
    output logic                 err
);
    logic [DATA_W-1:0] shreg;
    logic              bad;
    logic              in_data;

    assign in_data = (rise_idx >= FIRST_DATA_RISE) && (rise_idx <= LAST_DATA_RISE);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            bad    <= 1'b0;
            result <= '0;
            valid  <= 1'b0;
            err    <= 1'b0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            if (rise_stb) begin
                if (in_data)                                shreg <= {shreg[DATA_W-2:0], sdo};
                else if (sdo && rise_idx <= LAST_ZERO_RISE) bad   <= 1'b1;
            end
            if (frame_end) begin
                bad   <= 1'b0;
                valid <= (kind == FK_CONV);
                err   <= (kind != FK_SLEEP) && bad;
                if (kind == FK_CONV) result <= shreg;
            end
        end
    end

    assert_valid_only_conv_R7: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(kind == FK_CONV) && $past(frame_end));
    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    assert_no_err_on_sleep_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(kind != FK_SLEEP));
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DIV_W      = 4,
    parameter int SLEEP_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sleep_i,
    input  logic              wake_i,
    input  logic              long_frame_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              sdo_i,
    output logic              cs_n_o,
    output logic              sck_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              busy_o
);
    logic                 tmr_load, tmr_done, rise_stb, frame_end;
    logic [DIV_W:0]       tmr_val;
    logic [CLK_CNT_W-1:0] rise_idx;
    frame_kind_e          kind;

    adc_rd_timer #(.W(DIV_W + 1)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
    );

    adc_rd_seq #(.DIV_W(DIV_W), .SLEEP_CLKS(SLEEP_CLKS)) u_seq (
        .clk(clk), .rst(rst), .start(start_i), .sleep_req(sleep_i), .wake_req(wake_i),
        .long_frame(long_frame_i), .div(div_i), .tmr_done(tmr_done),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .cs_n(cs_n_o), .sck(sck_o),
        .busy(busy_o), .rise_stb(rise_stb), .rise_idx(rise_idx),
        .frame_end(frame_end), .kind(kind)
    );

    adc_rd_capture u_cap (
        .clk(clk), .rst(rst), .rise_stb(rise_stb), .rise_idx(rise_idx), .sdo(sdo_i),
        .frame_end(frame_end), .kind(kind), .result(result_o), .valid(valid_o), .err(err_o)
    );
endmodule

// File: tb/adc_rd_ctrl_test.sv
`timescale 1ns/1ps
module adc_rd_ctrl_test;
    logic        clk = 1'b0, rst = 1'b1;
    logic        start_i = 0, sleep_i = 0, wake_i = 0, long_frame_i = 1;
    logic [3:0]  div_i = 0;
    logic        sdo_i = 0;
    logic        cs_n_o, sck_o, valid_o, err_o, busy_o;
    logic [11:0] result_o;

    always #2 clk = ~clk;

    adc_rd_ctrl uut (.*);

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    always @(negedge clk) cyc++;

    // converter model: index 0 on chip-select fall, next index on each sck fall
    logic [15:0] mword = 16'h0;
    int idx = 0, falls = 0, t_cs = 0, t_first = 0, t_csr = 0, gap = 0, low_len = 0, rises = 0;
    always @(negedge cs_n_o or negedge sck_o) begin
        if (sck_o) begin
            idx = 0; falls = 0; rises = 0; gap = cyc - t_csr; t_cs = cyc;
            sdo_i = mword[15];
        end else if (!cs_n_o) begin
            falls++; idx++;
            if (falls == 1) t_first = cyc;
            sdo_i = (idx < 16) ? mword[15-idx] : 1'b0;
        end
    end
    always @(posedge sck_o) if (!cs_n_o) begin
        rises++;
        if (rises == 1) low_len = cyc - t_first;
    end
    always @(posedge cs_n_o) t_csr = cyc;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int v_cnt, e_cnt;
    logic [11:0] res;
    task automatic run(input logic lf, input logic [3:0] dv, input logic st, input logic sl,
                       input logic wk, input logic [15:0] word, input int poke_at);
        int n;
        @(negedge clk);
        long_frame_i = lf; div_i = dv; start_i = st; sleep_i = sl; wake_i = wk; mword = word;
        @(negedge clk);
        start_i = 0; sleep_i = 0; wake_i = 0;
        v_cnt = 0; e_cnt = 0; n = 0;
        while (busy_o && n < 3000) begin
            if (valid_o) begin v_cnt++; res = result_o; end
            if (err_o) e_cnt++;
            if (n == poke_at) begin sleep_i = 1; start_i = 1; end
            else begin sleep_i = 0; start_i = 0; end
            @(negedge clk); n++;
        end
        sleep_i = 0; start_i = 0;
        if (n >= 3000) chk(0, "watchdog", n, 0);
    endtask

    // {long_frame, div, sample}
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 4'd0, 12'hA5C}, {1'b0, 4'd0, 12'h3C1}, {1'b1, 4'd3, 12'hFFF},
        {1'b0, 4'd2, 12'h000}, {1'b1, 4'd1, 12'h801}, {1'b0, 4'd5, 12'h7FE}
    };

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o && sck_o && !busy_o && !valid_o && !err_o, "R1 reset",
            {cs_n_o, sck_o, busy_o, valid_o, err_o}, 5'b11000);
        rst = 0;
        @(negedge clk);
        chk(cs_n_o && sck_o && !busy_o && !valid_o && !err_o, "R1 after reset",
            {cs_n_o, sck_o, busy_o, valid_o, err_o}, 5'b11000);

        foreach (VEC[i]) begin
            run(VEC[i][16], VEC[i][15:12], 1, 0, 0, {2'b00, VEC[i][11:0], 2'b00}, -1);
            chk(falls == (VEC[i][16] ? 16 : 14), "R3 frame length", falls, VEC[i][16] ? 16 : 14);
            chk(v_cnt == 1, "R5 valid count", v_cnt, 1);
            chk(res == VEC[i][11:0], "R4 result", res, VEC[i][11:0]);
            chk(t_first - t_cs == int'(VEC[i][15:12]) + 1, "R2 setup", t_first - t_cs,
                int'(VEC[i][15:12]) + 1);
            chk(low_len == int'(VEC[i][15:12]) + 1, "R2 half period", low_len,
                int'(VEC[i][15:12]) + 1);
            chk(e_cnt == 0, "R8 clean frame", e_cnt, 0);
        end

        // R6 sleep frame
        run(1, 1, 0, 1, 0, 16'h0, -1);
        chk(falls == 4, "R6 sleep falls", falls, 4);
        chk(v_cnt == 0 && e_cnt == 0, "R6 no strobe", v_cnt + e_cnt, 0);
        // R7 wake frame (R10 wake beats sleep)
        run(0, 1, 0, 1, 1, 16'h3FFC, -1);
        chk(falls == 16, "R7 R10 wake falls", falls, 16);
        chk(v_cnt == 0, "R7 no valid", v_cnt, 0);
        // R10 sleep beats start
        run(1, 0, 1, 1, 0, 16'h3FFC, -1);
        chk(falls == 4 && v_cnt == 0, "R10 sleep over start", falls, 4);
        // R10 requests mid-frame ignored
        run(1, 0, 1, 0, 0, {2'b00, 12'h5A5, 2'b00}, 7);
        chk(falls == 16 && v_cnt == 1 && res == 12'h5A5, "R10 busy ignore", res, 12'h5A5);
        chk(!busy_o && cs_n_o, "R10 no second frame", busy_o, 0);
        // R8 error cases
        run(1, 0, 1, 0, 0, 16'h4000 | {2'b00, 12'h123, 2'b00}, -1);
        chk(e_cnt == 1 && res == 12'h123, "R8 leading zero", e_cnt, 1);
        run(0, 0, 1, 0, 0, 16'h0002, -1);
        chk(e_cnt == 1, "R8 trailing zero short", e_cnt, 1);
        run(0, 0, 1, 0, 0, 16'h0001, -1);
        chk(e_cnt == 0, "R8 unsampled position", e_cnt, 0);
        run(1, 0, 1, 0, 0, 16'h0001, -1);
        chk(e_cnt == 1, "R8 last trailing zero long", e_cnt, 1);
        run(1, 0, 0, 0, 1, 16'h4000, -1);
        chk(e_cnt == 1 && v_cnt == 0, "R8 R7 wake checked", e_cnt, 1);

        // R9 and R11: start held across two frames
        @(negedge clk);
        long_frame_i = 0; div_i = 2; start_i = 1; mword = 16'h0;
        @(negedge clk);
        chk(busy_o && !cs_n_o, "R11 busy with cs", {busy_o, cs_n_o}, 2'b10);
        while (!cs_n_o) @(negedge clk);
        while (cs_n_o) @(negedge clk);
        start_i = 0;
        chk(gap >= 6, "R9 quiet gap", gap, 6);
        while (busy_o) @(negedge clk);
        chk(!busy_o && cs_n_o && sck_o, "R11 idle after gap", busy_o, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(190000 * 4);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule